// File: doc/BRIEF.md
# Multichannel ADC Interface Sequencer

This block is the digital control inside a simultaneous-sampling converter that has two input groups of four channels each. A host reaches it through a parallel port made of active-low chip-select, write, read and convert-start strobes, a 12-bit bidirectional data bus and an active-low interrupt. The host writes a 4-bit mode word on the low bus bits to pick a group, a channel count or power-down. A convert-start pulse then captures every channel of the chosen group at once and runs a timed conversion, 20 clock cycles per channel. When the last channel is done, the interrupt goes low.

The host then reads the results one after another. A pointer moves forward on each completed read and returns to the first slot after four reads. The analog front end is modelled by a digital sample bus, which is snapshotted at the start of a conversion. All host strobes are asynchronous to the block clock. They pass through a synchronizer and an edge detector before they are used.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, int_no is high, the data bus is not driven, and the mode is 0000 (group A, one channel). A conversion started with no mode write therefore converts group A channel 1 only.
- R2: The mode word on data_io[3:0] is stored when either wr_ni or cs_ni rises while both were low. Whichever of the two rises first does the latching. The mode then stays in force for later conversions until it is written again.
- R3: For a mode with bit 3 clear, bit 2 selects group A (0) or group B (1), and bits 1:0 give the channel count minus one.
- R4: A mode with bit 3 set is power-down, whatever bits 2:0 hold. In power-down a convert-start pulse starts no conversion, and int_no stays high.
- R5: The group's samples are taken when the rising edge of convst_ni arrives after synchronization. Later changes on sample_i do not alter the stored results.
- R6: Take CONVST as driven high between clock edges, and count N programmed channels. int_no then goes low on rising clock edge number 20*N+3 after that point, and not before.
- R7: A convert-start pulse that arrives during a conversion is ignored. The conversion keeps its timing and its captured samples.
- R8: The first falling edge of rd_ni with cs_ni low sets int_no high again.
- R9: While cs_ni and rd_ni are both low, data_io carries the 12-bit result from the slot the pointer selects. Slot k holds channel k+1 of the group. Slots beyond the programmed count read as zero. Otherwise the bus is released.
- R10: Each rising edge of rd_ni with cs_ni low advances the pointer. After four reads the pointer returns to slot 0, whatever the channel count.
- R11: Every convert-start pulse returns the pointer to slot 0. This holds even when the pulse starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, 20 cycles per channel conversion |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| convst_ni | input | 1 | Convert-start strobe; the sequence starts on its rising edge |
| sample_i | input | 96 | Digital samples; channel c of group g at bits [(4g+c)*12 +: 12] |
| data_io | inout | 12 | Mode word in (bits 3:0), result out |
| int_no | output | 1 | End-of-sequence interrupt, active low |

## Verification
A table walks all eight active modes, from one to four channels on each group. Each mode gets a fresh sample pattern, and the pattern is swapped partway through the conversion. These runs separate the group selection from the channel count. They also separate per-count timing from a fixed delay, and a snapshot taken at start from samples read live. Directed cases add several things on top of the table:
- the default mode after reset
- a fifth read, which must wrap to slot 0
- a pointer reset by a convert pulse in power-down, where the results left in the slots must be unchanged
- a second convert pulse in mid-conversion
- a mode latched by chip-select rising before write, which must then persist for a second conversion

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_PER_GRP = 4;
  localparam int unsigned NUM_GRP    = 2;
  localparam int unsigned MODE_W     = 4;
  localparam int unsigned CH_IDX_W   = $clog2(CH_PER_GRP);
  localparam int unsigned NUM_STB    = 4;

  // strobe positions in the synchronizer vector
  localparam int unsigned STB_CS   = 0;
  localparam int unsigned STB_WR   = 1;
  localparam int unsigned STB_RD   = 2;
  localparam int unsigned STB_CONV = 3;

  typedef struct packed {
    logic                pwr_dn;
    logic                grp_b;
    logic [CH_IDX_W-1:0] last_ch;
  } mode_t;
endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int unsigned W       = 8,
  parameter int unsigned EDGE_W  = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      async_i,
  output logic [W-1:0]      sync_o,
  output logic [EDGE_W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [EDGE_W-1:0]        prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL[EDGE_W-1:0];
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1][EDGE_W-1:0];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_CH = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_we_i,
  input  logic [MODE_W-1:0]   mode_d_i,
  input  logic                conv_rise_i,
  input  logic                rd_fall_i,
  output logic                start_o,
  output logic                grp_o,
  output logic                wr_en_o,
  output logic [CH_IDX_W-1:0] wr_ch_o,
  output logic                int_no
);
  localparam int unsigned CYC_W = (CYC_PER_CH > 1) ? $clog2(CYC_PER_CH) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_CH - 1);

  mode_t               mode_q;
  logic                busy_q;
  logic [CYC_W-1:0]    cyc_q;
  logic [CH_IDX_W-1:0] ch_q, last_q;
  logic                ch_end, done_now, start;

  assign start    = conv_rise_i & ~busy_q & ~mode_q.pwr_dn;
  assign ch_end   = busy_q & (cyc_q == CYC_LAST);
  assign done_now = ch_end & (ch_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_t'(mode_d_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      ch_q   <= '0;
      last_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cyc_q  <= '0;
      ch_q   <= '0;
      last_q <= mode_q.last_ch;
    end else if (busy_q) begin
      if (ch_end) begin
        cyc_q <= '0;
        if (done_now) busy_q <= 1'b0;
        else          ch_q   <= ch_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 int_no <= 1'b1;
    else if (done_now)           int_no <= 1'b0;
    else if (rd_fall_i || start) int_no <= 1'b1;
  end

  assign start_o = start;
  assign grp_o   = mode_q.grp_b;
  assign wr_en_o = ch_end;
  assign wr_ch_o = ch_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_q)); // R2
  AST_PD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_rise_i && mode_q.pwr_dn && !busy_q) |=> !busy_q); // R4
  AST_INT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> ($past(busy_q) && !busy_q)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_rise_i && busy_q && !done_now) |=> (busy_q && $stable(last_q))); // R7
  AST_INT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall_i && !done_now) |=> int_no); // R8
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic                                 grp_i,
  input  logic [NUM_GRP*CH_PER_GRP*RES_W-1:0]  sample_i,
  input  logic                                 wr_en_i,
  input  logic [CH_IDX_W-1:0]                  wr_ch_i,
  input  logic                                 ptr_clr_i,
  input  logic                                 ptr_inc_i,
  output logic [RES_W-1:0]                     rdata_o
);
  logic [RES_W-1:0]    grp_smp [CH_PER_GRP];
  logic [RES_W-1:0]    hold_q  [CH_PER_GRP];
  logic [RES_W-1:0]    slot_q  [CH_PER_GRP];
  logic [CH_IDX_W-1:0] ptr_q;

  for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_mux
    assign grp_smp[c] = grp_i ? sample_i[(CH_PER_GRP + c)*RES_W +: RES_W]
                              : sample_i[c*RES_W +: RES_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CH_PER_GRP; c++) begin
        hold_q[c] <= '0;
        slot_q[c] <= '0;
      end
    end else if (start_i) begin
      for (int c = 0; c < CH_PER_GRP; c++) begin
        hold_q[c] <= grp_smp[c];
        slot_q[c] <= '0;
      end
    end else if (wr_en_i) begin
      slot_q[wr_ch_i] <= hold_q[wr_ch_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (ptr_clr_i) ptr_q <= '0;
    else if (ptr_inc_i) ptr_q <= ptr_q + 1'b1;
  end

  assign rdata_o = slot_q[ptr_q];

  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> (ptr_q == '0)); // R11
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_inc_i && !ptr_clr_i) |=> (ptr_q == CH_IDX_W'($past(ptr_q) + 1'b1))); // R10
  AST_SLOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (slot_q[CH_PER_GRP-1] == '0)); // R9
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W       = 12,
  parameter int unsigned CYC_PER_CH  = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                cs_ni,
  input  logic                                wr_ni,
  input  logic                                rd_ni,
  input  logic                                convst_ni,
  input  logic [NUM_GRP*CH_PER_GRP*RES_W-1:0] sample_i,
  inout  wire  [RES_W-1:0]                    data_io,
  output logic                                int_no
);
  localparam int unsigned SYNC_W = NUM_STB + MODE_W;

  logic [SYNC_W-1:0]   s;
  logic [NUM_STB-1:0]  p;
  logic                mode_we, conv_rise, rd_fall, rd_rise, cs_low;
  logic                start, grp, wr_en;
  logic [CH_IDX_W-1:0] wr_ch;
  logic [RES_W-1:0]    rdata;

  adc_strobe_sync #(
    .W(SYNC_W), .EDGE_W(NUM_STB), .STAGES(SYNC_STAGES),
    .RST_VAL({{MODE_W{1'b0}}, {NUM_STB{1'b1}}})
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({data_io[MODE_W-1:0], convst_ni, rd_ni, wr_ni, cs_ni}),
    .sync_o  (s),
    .prev_o  (p)
  );

  assign cs_low    = ~s[STB_CS];
  assign mode_we   = ~p[STB_CS] & ~p[STB_WR] & (s[STB_CS] | s[STB_WR]);
  assign conv_rise = s[STB_CONV] & ~p[STB_CONV];
  assign rd_fall   = ~s[STB_RD] & p[STB_RD] & cs_low;
  assign rd_rise   = s[STB_RD] & ~p[STB_RD] & cs_low;

  adc_conv_seq #(.CYC_PER_CH(CYC_PER_CH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_we_i   (mode_we),
    .mode_d_i    (s[SYNC_W-1:NUM_STB]),
    .conv_rise_i (conv_rise),
    .rd_fall_i   (rd_fall),
    .start_o     (start),
    .grp_o       (grp),
    .wr_en_o     (wr_en),
    .wr_ch_o     (wr_ch),
    .int_no      (int_no)
  );

  adc_result_bank #(.RES_W(RES_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .grp_i     (grp),
    .sample_i  (sample_i),
    .wr_en_i   (wr_en),
    .wr_ch_i   (wr_ch),
    .ptr_clr_i (conv_rise),
    .ptr_inc_i (rd_rise),
    .rdata_o   (rdata)
  );

  assign data_io = (!cs_ni && !rd_ni) ? rdata : {RES_W{1'bz}};
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int RES_W = 12;
  localparam int CYC   = 20;
  localparam int CAP   = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, conv_n = 1'b1;
  logic [2*4*RES_W-1:0] smp_bus = '0;
  logic drv_en = 1'b0;
  logic [RES_W-1:0] drv_val = '0;
  wire  [RES_W-1:0] data_io;
  logic int_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign data_io = drv_en ? drv_val : {RES_W{1'bz}};

  always #5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .convst_ni(conv_n), .sample_i(smp_bus), .data_io(data_io), .int_no(int_n)
  );

  // {mode[3:0], group, channel count[2:0]}
  localparam logic [7:0] VEC [8] = '{8'h34, 8'h01, 8'h6B, 8'h12, 8'h7C, 8'h49, 8'h23, 8'h5A};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] smp(int seed, int g, int c);
    return RES_W'(seed * 12'h131 + g * 12'h40 + c * 12'h9 + 12'h8);
  endfunction

  task automatic load(int seed);
    for (int g = 0; g < 2; g++)
      for (int c = 0; c < 4; c++)
        smp_bus[(g*4+c)*RES_W +: RES_W] = smp(seed, g, c);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [3:0] m, input bit cs_first);
    @(negedge clk);
    drv_en = 1'b1; drv_val = {8'h00, m};
    cs_n = 1'b0; wr_n = 1'b0; cyc(4);
    if (cs_first) begin cs_n = 1'b1; cyc(4); wr_n = 1'b1; end
    else begin wr_n = 1'b1; cyc(4); cs_n = 1'b1; end
    cyc(4); drv_en = 1'b0;
  endtask

  task automatic rd_one(output logic [RES_W-1:0] v);
    cs_n = 1'b0; cyc(2);
    rd_n = 1'b0; cyc(4);
    v = data_io;
    rd_n = 1'b1; cyc(3);
    cs_n = 1'b1; cyc(3);
  endtask

  // edges from CONVST high until int low; swaps samples to seed_after at n==5
  task automatic conv_measure(input int seed_after, input bit extra_pulse, output int n);
    @(negedge clk); conv_n = 1'b0; cyc(4); conv_n = 1'b1;
    n = 0;
    while (int_n !== 1'b0 && n < CAP) begin
      @(posedge clk); @(negedge clk); n++;
      if (n == 5) load(seed_after);
      if (extra_pulse && n == 30) conv_n = 1'b0;
      if (extra_pulse && n == 34) conv_n = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RES_W-1:0] v;
    int n;
    cyc(3); rst_n = 1'b1; cyc(2);

    // R1 reset state
    check("R1 int after reset", int_n, 1'b1);
    drv_en = 1'b1; drv_val = 12'h5A3; cyc(1);
    check("R1 bus released", data_io, 12'h5A3);
    drv_en = 1'b0;

    // R1 default mode, R10 wrap after four reads
    load(50);
    conv_measure(51, 1'b0, n);
    check("R1 R6 default one-channel timing", n, 20*1 + 3);
    rd_one(v); check("R1 R9 default slot0", v, smp(50, 0, 0));
    check("R8 int cleared", int_n, 1'b1);
    for (int r = 1; r < 4; r++) begin rd_one(v); check("R9 unconverted slot zero", v, '0); end
    rd_one(v); check("R10 wrap to slot0", v, smp(50, 0, 0));

    // table of modes: R2 R3 R5 R6 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [3:0] m; logic g; int cnt;
      m = VEC[i][7:4]; g = VEC[i][3]; cnt = int'(VEC[i][2:0]);
      wr_mode(m, 1'b0);
      load(i);
      conv_measure(i + 100, 1'b0, n);
      check("R6 timing per count", n, 20*cnt + 3);
      check("R6 int low at end", int_n, 1'b0);
      for (int r = 0; r < 4; r++) begin
        rd_one(v);
        if (r == 0) check("R8 int high after first read", int_n, 1'b1);
        check("R3 R5 R9 result slot", v, (r < cnt) ? 32'(smp(i, int'(g), r)) : 32'h0);
      end
    end

    // R4 power-down, R11 pointer reset by ignored pulse
    wr_mode(4'h3, 1'b0);
    load(60);
    conv_measure(61, 1'b0, n);
    check("R6 four-channel timing", n, 83);
    rd_one(v); check("R9 slot0", v, smp(60, 0, 0));
    rd_one(v); check("R10 slot1", v, smp(60, 0, 1));
    wr_mode(4'hB, 1'b0);
    conv_measure(62, 1'b0, n);
    check("R4 no conversion in power-down", n, CAP);
    check("R4 int stays high", int_n, 1'b1);
    rd_one(v); check("R11 R4 pointer reset, data kept", v, smp(60, 0, 0));
    rd_one(v); check("R10 next slot after reset", v, smp(60, 0, 1));

    // R7 convert pulse mid-conversion
    wr_mode(4'h3, 1'b0);
    load(70);
    conv_measure(70, 1'b1, n);
    check("R7 timing unaffected", n, 83);
    for (int r = 0; r < 4; r++) begin rd_one(v); check("R7 first snapshot kept", v, smp(70, 0, r)); end

    // R2 latch on CS rising first, then persistence
    wr_mode(4'h6, 1'b1);
    load(80);
    conv_measure(81, 1'b0, n);
    check("R2 cs-first latch timing", n, 63);
    for (int r = 0; r < 4; r++) begin
      rd_one(v); check("R2 group B results", v, (r < 3) ? 32'(smp(80, 1, r)) : 32'h0);
    end
    load(90);
    conv_measure(91, 1'b0, n);
    check("R2 mode persists", n, 63);
    rd_one(v); check("R2 persisted group", v, smp(90, 1, 0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule